// File: doc/BRIEF.md
# SMBus Host Controller Register Front-End

This block is the software-visible side of an SMBus host controller. Software reaches eight byte-wide register offsets to set up a transaction: a control byte, a command byte, a target address with direction, two data bytes and a 32-byte block buffer. A write to the control register with the start bit set launches a transaction. The block then decodes the protocol code and the direction, captures the request fields and offers them to a transaction engine. The engine performs the bus cycles. On completion the block stores the returned bytes back into the data registers.

The serializer itself is not part of this block. It sits behind two valid/ready channels. On the request channel the block holds `req_valid` and every request field steady until the engine raises `req_ready`, so the engine may stall as long as it needs. On the response channel the block raises `rsp_ready` only while it is waiting for an outstanding transaction. A response offered at any other time stays pending. The engine reaches the block buffer directly through an indexed side port. It uses this port to fetch bytes for a block write and to deposit bytes for a block read.

The block buffer sits behind a single data offset with an auto-incrementing index. This lets software stream a whole block with repeated accesses to the same offset.

Top module: `smb_host_regs`

## Requirements
- R1: Offsets are 0 status, 2 control, 3 command, 4 address, 5 data0, 6 data1 and 7 block data. Offset 1 reads 0 and ignores writes. Command, address, data0 and data1 read back the last value written.
- R2: Control stores write bits 4:0 and reads them back with bits 7:5 as 0. Bits 4:2 are the protocol code. Writing bit 6 as 1 is the start command, and bit 6 is not stored.
- R3: A start while idle raises `req_valid` on the next cycle. `req_valid` and all request fields stay stable until `req_ready` is seen. The request fields are: `req_proto`, the protocol code; `req_target`, address bits 7:1; `req_read`, address bit 0 (1 = read, 0 = write); and `req_cmd`, the command byte. A start while busy is ignored.
- R4: For a write, `req_wdata` is set by protocol code. Codes 2 and 5 give {0, data0}; for code 5 this is the block byte count. Code 3 gives {data1, data0}. Codes 0 and 1 give 0. For any read, `req_wdata` is 0.
- R5: When a read response is accepted, `rsp_data` is written back by protocol code. Codes 1, 2 and 5 load data0 from bits 7:0; for code 5 this is the block count. Code 3 loads data0 from bits 7:0 and data1 from bits 15:8. Code 0 changes nothing. Write transactions change neither data register.
- R6: Status bit 0 (busy) is 1 from the cycle after an accepted start until the response is accepted. Status bit 1 (done) sets when the response is accepted. Writing 1 to a status bit clears it.
- R7: A start with protocol code 4, 6 or 7 issues no request and sets status bit 2 (fail). Fail is cleared by writing 1 to it.
- R8: Each read or write at offset 7 accesses the buffer byte at the current index and then increments the index. The index wraps from 31 to 0.
- R9: Any write to control with bit 6 set resets the block index to 0.
- R10: The engine side port writes a buffer byte when `eng_buf_we` is high. It returns the byte at `eng_buf_idx` on `eng_buf_rdata`.
- R11: After reset, all registers and the index are 0, and `req_valid` and `rsp_ready` are low.
- R12: `rsp_ready` is high only in the cycles between request acceptance and response acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances block index at offset 7) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| req_valid | output | 1 | Request offered to engine |
| req_ready | input | 1 | Engine accepts request |
| req_proto | output | 3 | Protocol code |
| req_read | output | 1 | 1 = read transaction |
| req_target | output | 7 | Target device address |
| req_cmd | output | 8 | Command byte |
| req_wdata | output | 16 | Write payload or block count |
| rsp_valid | input | 1 | Engine response valid |
| rsp_ready | output | 1 | Block accepts response |
| rsp_data | input | 16 | Returned read data |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_idx | input | 5 | Engine buffer index |
| eng_buf_wdata | input | 8 | Engine buffer write byte |
| eng_buf_rdata | output | 8 | Buffer byte at `eng_buf_idx` |

## Verification
The assertions check four things on every cycle:
- the request handshake holds `req_valid` and its payload until acceptance;
- `rsp_ready` appears only while a transaction is outstanding;
- done rises only on an accepted response, and an unsupported code never produces a request;
- the block index wraps from 31 to 0 and clears on start.

The per-protocol payload mapping, the data write-back rules, the register readback masks and the write-1-to-clear behaviour are visible only in the bench's directed scenarios. Those scenarios compare register contents and request fields against values worked out from the requirements.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int DW = 8;

  localparam logic [2:0] OFS_STAT = 3'd0;
  localparam logic [2:0] OFS_CTL  = 3'd2;
  localparam logic [2:0] OFS_CMD  = 3'd3;
  localparam logic [2:0] OFS_ADR  = 3'd4;
  localparam logic [2:0] OFS_D0   = 3'd5;
  localparam logic [2:0] OFS_D1   = 3'd6;
  localparam logic [2:0] OFS_BLK  = 3'd7;

  localparam logic [2:0] PR_QUICK = 3'd0;
  localparam logic [2:0] PR_BYTE  = 3'd1;
  localparam logic [2:0] PR_BDATA = 3'd2;
  localparam logic [2:0] PR_WORD  = 3'd3;
  localparam logic [2:0] PR_BLOCK = 3'd5;

  localparam int CTL_START_BIT = 6;

  function automatic logic proto_ok(input logic [2:0] p);
    return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
           (p == PR_WORD) || (p == PR_BLOCK);
  endfunction
endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_idx,
  input  logic             port_wr,
  input  logic             port_rd,
  input  logic [DW-1:0]    port_wdata,
  output logic [DW-1:0]    port_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [DW-1:0]    eng_wdata,
  output logic [DW-1:0]    eng_rdata
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (port_wr) mem[idx_q] <= port_wdata;
      if (eng_we)  mem[eng_idx] <= eng_wdata;
      if (clr_idx)
        idx_q <= '0;
      else if (port_wr || port_rd)
        idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  assign port_rdata = mem[idx_q];
  assign eng_rdata  = mem[eng_idx];

  p_idx_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_wr || port_rd) && !clr_idx && idx_q == LAST) |=> idx_q == '0);
  p_idx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_idx |=> idx_q == '0);
endmodule

// File: rtl/smb_txn_seq.sv
module smb_txn_seq
  import smb_host_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  proto,
  input  logic [7:0]  adr,
  input  logic [7:0]  cmd,
  input  logic [7:0]  d0,
  input  logic [7:0]  d1,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [2:0]  req_proto,
  output logic        req_read,
  output logic [6:0]  req_target,
  output logic [7:0]  req_cmd,
  output logic [15:0] req_wdata,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [15:0] rsp_data,
  output logic        busy,
  output logic        done_pulse,
  output logic        fail_pulse,
  output logic        wb_lo_en,
  output logic        wb_hi_en,
  output logic [15:0] wb_data
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_t;
  st_t st_q;

  logic        launch;
  logic [15:0] wdata_sel;

  assign launch     = start && (st_q == ST_IDLE) && proto_ok(proto);
  assign fail_pulse = start && (st_q == ST_IDLE) && !proto_ok(proto);

  always_comb begin
    wdata_sel = '0;
    if (!adr[0]) begin
      case (proto)
        PR_BDATA, PR_BLOCK: wdata_sel = {8'h00, d0};
        PR_WORD:            wdata_sel = {d1, d0};
        default:            wdata_sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      req_proto  <= '0;
      req_read   <= 1'b0;
      req_target <= '0;
      req_cmd    <= '0;
      req_wdata  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q       <= ST_REQ;
          req_proto  <= proto;
          req_read   <= adr[0];
          req_target <= adr[7:1];
          req_cmd    <= cmd;
          req_wdata  <= wdata_sel;
        end
        ST_REQ:  if (req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid  = (st_q == ST_REQ);
  assign rsp_ready  = (st_q == ST_WAIT);
  assign busy       = (st_q != ST_IDLE);
  assign done_pulse = rsp_ready && rsp_valid;
  assign wb_lo_en   = done_pulse && req_read && (req_proto != PR_QUICK);
  assign wb_hi_en   = done_pulse && req_read && (req_proto == PR_WORD);
  assign wb_data    = rsp_data;

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_wdata) &&
      $stable(req_target) && $stable(req_proto) && $stable(req_cmd)));
  p_rsp_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (busy && !req_valid));
  p_bad_proto_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |=> !req_valid);
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [2:0]       req_proto,
  output logic             req_read,
  output logic [6:0]       req_target,
  output logic [7:0]       req_cmd,
  output logic [15:0]      req_wdata,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [15:0]      rsp_data,
  input  logic             eng_buf_we,
  input  logic [IDX_W-1:0] eng_buf_idx,
  input  logic [7:0]       eng_buf_wdata,
  output logic [7:0]       eng_buf_rdata
);
  logic [4:0] ctl_q;
  logic [7:0] cmd_q, adr_q, d0_q, d1_q;
  logic       done_q, fail_q;

  logic        start, busy, done_pulse, fail_pulse, wb_lo_en, wb_hi_en;
  logic [15:0] wb_data;
  logic [7:0]  blk_rdata;
  logic        wr_stat, wr_ctl;

  assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
  assign wr_ctl  = reg_wr && (reg_addr == OFS_CTL);
  assign start   = wr_ctl && reg_wdata[CTL_START_BIT];

  smb_txn_seq u_seq (
    .clk, .rst_n, .start,
    .proto(reg_wdata[4:2]), .adr(adr_q), .cmd(cmd_q), .d0(d0_q), .d1(d1_q),
    .req_valid, .req_ready, .req_proto, .req_read, .req_target, .req_cmd,
    .req_wdata, .rsp_valid, .rsp_ready, .rsp_data,
    .busy, .done_pulse, .fail_pulse, .wb_lo_en, .wb_hi_en, .wb_data
  );

  smb_blk_buf #(.DEPTH(BUF_DEPTH), .DW(DW)) u_buf (
    .clk, .rst_n, .clr_idx(start),
    .port_wr(reg_wr && reg_addr == OFS_BLK),
    .port_rd(reg_rd && reg_addr == OFS_BLK),
    .port_wdata(reg_wdata), .port_rdata(blk_rdata),
    .eng_we(eng_buf_we), .eng_idx(eng_buf_idx),
    .eng_wdata(eng_buf_wdata), .eng_rdata(eng_buf_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      cmd_q  <= '0;
      adr_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= reg_wdata[4:0];
      if (reg_wr && reg_addr == OFS_CMD) cmd_q <= reg_wdata;
      if (reg_wr && reg_addr == OFS_ADR) adr_q <= reg_wdata;
      if (wb_lo_en) d0_q <= wb_data[7:0];
      else if (reg_wr && reg_addr == OFS_D0) d0_q <= reg_wdata;
      if (wb_hi_en) d1_q <= wb_data[15:8];
      else if (reg_wr && reg_addr == OFS_D1) d1_q <= reg_wdata;
      if (done_pulse) done_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) done_q <= 1'b0;
      if (fail_pulse) fail_q <= 1'b1;
      else if (wr_stat && reg_wdata[2]) fail_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = {5'b0, fail_q, done_q, busy};
      OFS_CTL:  reg_rdata = {3'b0, ctl_q};
      OFS_CMD:  reg_rdata = cmd_q;
      OFS_ADR:  reg_rdata = adr_q;
      OFS_D0:   reg_rdata = d0_q;
      OFS_D1:   reg_rdata = d1_q;
      OFS_BLK:  reg_rdata = blk_rdata;
      default:  reg_rdata = '0;
    endcase
  end

  p_done_after_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(rsp_valid && rsp_ready));
  p_busy_until_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(rsp_valid && rsp_ready)) |=> busy);
endmodule

// File: tb/smb_host_regs_tb_top.sv
module smb_host_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        req_valid, req_ready = 0, req_read;
  logic [2:0]  req_proto;
  logic [6:0]  req_target;
  logic [7:0]  req_cmd;
  logic [15:0] req_wdata;
  logic        rsp_valid = 0, rsp_ready;
  logic [15:0] rsp_data = '0;
  logic        eng_buf_we = 0;
  logic [4:0]  eng_buf_idx = '0;
  logic [7:0]  eng_buf_wdata = '0, eng_buf_rdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  smb_host_regs dut_i (.*);

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    reg_read(a, v);
    check(req, {8'h0, v}, {8'h0, exp});
  endtask

  task automatic serve(input logic [15:0] rdat);
    int guard = 0;
    while (!req_valid && guard < 50) begin @(negedge clk); guard++; end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    check("R12 rsp_ready in wait", {15'h0, rsp_ready}, 16'h1);
    rsp_valid = 1; rsp_data = rdat;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic t_reset;
    rd_check("R11 status reset", 3'd0, 8'h00);
    rd_check("R11 data0 reset", 3'd5, 8'h00);
    rd_check("R11 block reset", 3'd7, 8'h00);
    check("R11 req_valid low", {15'h0, req_valid}, 16'h0);
    check("R11 rsp_ready low", {15'h0, rsp_ready}, 16'h0);
  endtask

  task automatic t_regs;
    reg_write(3'd3, 8'hA5); reg_write(3'd4, 8'h3C);
    reg_write(3'd5, 8'h11); reg_write(3'd6, 8'h22);
    reg_write(3'd1, 8'hFF);
    rd_check("R1 command", 3'd3, 8'hA5);
    rd_check("R1 address", 3'd4, 8'h3C);
    rd_check("R1 data0", 3'd5, 8'h11);
    rd_check("R1 data1", 3'd6, 8'h22);
    rd_check("R1 offset1 zero", 3'd1, 8'h00);
    reg_write(3'd2, 8'hBF);
    rd_check("R2 control mask", 3'd2, 8'h1F);
    check("R2 no start without bit6", {15'h0, req_valid}, 16'h0);
  endtask

  task automatic t_word_write;
    reg_write(3'd4, 8'hA0); reg_write(3'd3, 8'h12);
    reg_write(3'd5, 8'h34); reg_write(3'd6, 8'h56);
    reg_write(3'd2, 8'h4C);
    rd_check("R6 busy after start", 3'd0, 8'h01);
    repeat (3) @(negedge clk);
    check("R3 valid held under stall", {15'h0, req_valid}, 16'h1);
    check("R12 no rsp_ready before accept", {15'h0, rsp_ready}, 16'h0);
    check("R3 proto", {13'h0, req_proto}, 16'h3);
    check("R3 read bit", {15'h0, req_read}, 16'h0);
    check("R3 target", {9'h0, req_target}, 16'h50);
    check("R3 cmd", {8'h0, req_cmd}, 16'h12);
    check("R4 word payload", req_wdata, 16'h5634);
    req_ready = 1; @(negedge clk); req_ready = 0;
    reg_write(3'd2, 8'h44);
    check("R3 start while busy ignored", {15'h0, req_valid}, 16'h0);
    rsp_valid = 1; rsp_data = 16'hFFFF; @(negedge clk); rsp_valid = 0;
    rd_check("R6 done set", 3'd0, 8'h02);
    rd_check("R5 write leaves data0", 3'd5, 8'h34);
    rd_check("R5 write leaves data1", 3'd6, 8'h56);
    reg_write(3'd0, 8'h02);
    rd_check("R6 done W1C", 3'd0, 8'h00);
  endtask

  task automatic t_reads;
    reg_write(3'd4, 8'hA1);
    reg_write(3'd2, 8'h4C);
    check("R4 read payload zero", req_wdata, 16'h0);
    check("R3 read bit set", {15'h0, req_read}, 16'h1);
    serve(16'hBEEF);
    rd_check("R5 word lo", 3'd5, 8'hEF);
    rd_check("R5 word hi", 3'd6, 8'hBE);
    reg_write(3'd6, 8'h77);
    reg_write(3'd2, 8'h44);
    serve(16'h1234);
    rd_check("R5 byte read data0", 3'd5, 8'h34);
    rd_check("R5 byte read data1 kept", 3'd6, 8'h77);
    reg_write(3'd5, 8'h99);
    reg_write(3'd2, 8'h40);
    serve(16'hAAAA);
    rd_check("R5 quick no writeback", 3'd5, 8'h99);
    reg_write(3'd0, 8'h02);
  endtask

  task automatic t_bad;
    reg_write(3'd2, 8'h50);
    rd_check("R7 fail set", 3'd0, 8'h04);
    repeat (2) @(negedge clk);
    check("R7 no request", {15'h0, req_valid}, 16'h0);
    reg_write(3'd0, 8'h04);
    rd_check("R7 fail W1C", 3'd0, 8'h00);
  endtask

  task automatic t_block;
    logic [7:0] v;
    reg_write(3'd7, 8'h10); reg_write(3'd7, 8'h11); reg_write(3'd7, 8'h12);
    eng_buf_idx = 5'd1; #1;
    check("R10 engine reads buffer", {8'h0, eng_buf_rdata}, 16'h11);
    reg_write(3'd4, 8'hA0); reg_write(3'd5, 8'h03);
    reg_write(3'd2, 8'h54);
    check("R4 block count payload", req_wdata, 16'h0003);
    serve(16'h0000);
    rd_check("R9 index reset by start", 3'd7, 8'h10);
    for (int i = 1; i < 32; i++) reg_write(3'd7, 8'h80 + 8'(i));
    rd_check("R8 index wraps to 0", 3'd7, 8'h10);
    rd_check("R8 index then 1", 3'd7, 8'h81);
    reg_write(3'd4, 8'hA1);
    reg_write(3'd2, 8'h54);
    eng_buf_we = 1; eng_buf_idx = 5'd0; eng_buf_wdata = 8'hC0;
    @(negedge clk); eng_buf_we = 0;
    serve(16'h0001);
    rd_check("R5 block count to data0", 3'd5, 8'h01);
    reg_read(3'd7, v);
    check("R10 engine write seen at port", {8'h0, v}, 16'h00C0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_word_write();
    t_reads();
    t_bad();
    t_block();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule